// File: doc/BRIEF.md
# PDM Clock-Enable and Sample-Strobe Generator

This block derives every timing event a PDM microphone front end needs from a single input clock. It produces no gated or muxed clocks. Two cascaded prescalers produce clock enables: a core enable and a master enable. A phase counter running on the master enable shapes the registered bit-clock driven to the microphone pin. A sampler strobe fires a programmable number of core periods after each rising edge of that pin clock. On that strobe the PDM data input is captured. A decimation counter counts pin-clock periods and emits a one-cycle PCM sample strobe at the output word rate.

The divider, delay and rate settings are captured while the enable is low and frozen while it is high. A new setting applied during operation therefore takes effect only after the enable is dropped and raised again. Every counter restarts from a known phase at that point.

Top module: `pdm_clkgen`

## Requirements
- R1: The core enable divides the input clock by `core_div_sel + 1`, so the encodings 0 to 3 select division by 1 to 4.
- R2: The master enable divides the core enable by `mclk_div_sel + 1`, so the encodings 0 to 3 select division by 1 to 4.
- R3: `pdm_clk_o` has a period of (core divide) × (master divide) × (`out_div` + 1) input clock cycles, for `out_div` from 1 to 15.
- R4: `pdm_clk_o` stays high for (core divide) × (master divide) × floor((`out_div` + 2) / 2) input cycles of each period, which is ceil((N+1)/2) master periods.
- R5: `smp_stb_o` is a one-cycle pulse with at most one per `pdm_clk_o` period. It is asserted (core divide) × `smp_delay` input cycles after the cycle in which `pdm_clk_o` first reads high, which is the same cycle when `smp_delay` is 0. If that offset is not shorter than the pin-clock period, no strobe is produced.
- R6: On each sampler strobe, `smp_dat_o` shows the value `pdm_din` had at the clock edge that raised the strobe.
- R7: When `dec_rate` is R > 0, `pcm_stb_o` is a one-cycle pulse. It coincides with a rising edge of `pdm_clk_o`, first on the 2R-th rising edge after enable, then once every 2R pin-clock periods. When R = 0 it never fires.
- R8: Reset, or `en` low, clears all counters and drives every output low. Settings are captured only while `en` is low. Changing them while `en` is high has no effect on the output timing until `en` is cycled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from which all enables are derived |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears counters and loads settings |
| core_div_sel | input | 2 | First prescaler select, divide by value + 1 |
| mclk_div_sel | input | 2 | Second prescaler select, divide by value + 1 |
| out_div | input | 4 | Pin-clock divider N, divide master by N + 1 |
| smp_delay | input | 3 | Sampler offset after pin-clock rise, in core periods |
| dec_rate | input | 7 | Decimation setting; oversampling ratio is twice this value |
| pdm_din | input | 1 | Serial PDM data from the microphone |
| pdm_clk_o | output | 1 | Registered bit clock to the microphone |
| smp_stb_o | output | 1 | One-cycle sampler strobe |
| smp_dat_o | output | 1 | PDM bit captured on the last sampler strobe |
| pcm_stb_o | output | 1 | One-cycle PCM word-rate strobe |

## Verification
A prescaler counter in a wrong state stretches or shortens the pin-clock period and its high time, and this is visible within one or two pin-clock periods after enable. A wrong phase or delay counter moves the sampler strobe away from its fixed offset after the rising edge. It can also drop the strobe or add a second one. That shows in the first full period, and the captured data bit then disagrees with the driven input. A faulty decimation counter moves the PCM strobe off the 2R-th rising edge. It is seen only after up to 2R pin-clock periods, so each test case keeps the rate small enough that two strobe intervals fit in its window.

// File: rtl/pdm_clkgen_pkg.sv
package pdm_clkgen_pkg;
   // default field widths shared by the top and the bench-facing port list
   localparam int DEF_SEL_W  = 2;
   localparam int DEF_DIV_W  = 4;
   localparam int DEF_DLY_W  = 3;
   localparam int DEF_RATE_W = 7;
   // number of cascaded clock-enable prescalers ahead of the pin-clock shaper
   localparam int PRESCALE_STAGES = 2;
endpackage

// File: rtl/pdm_ce_div.sv
module pdm_ce_div #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick_i,
   input  logic [W-1:0] lim_i,
   output logic         tick_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (tick_i) begin
         cnt <= (cnt == lim_i) ? '0 : cnt + W'(1);
      end
   end

   assign tick_o = run && tick_i && (cnt == lim_i);

   // R1 / R2: the count never passes the programmed limit while running
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= lim_i));
endmodule

// File: rtl/pdm_clk_shaper.sv
module pdm_clk_shaper #(
   parameter int NW = 4,
   parameter int DW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          core_tick,
   input  logic          mclk_tick,
   input  logic [NW-1:0] n_i,
   input  logic [DW-1:0] d_i,
   input  logic          din,
   output logic          pdm_clk_o,
   output logic          rise_tick_o,
   output logic          smp_stb_o,
   output logic          smp_dat_o
);
   logic [NW-1:0] phase, nxt_phase;
   logic [NW:0]   half;
   logic          started, pdm_q, armed, stb_q, dat_q, wrap;
   logic [DW-1:0] dcnt;

   assign half      = ({1'b0, n_i} + (NW+1)'(2)) >> 1;
   assign wrap      = !started || (phase == n_i);
   assign nxt_phase = wrap ? '0 : phase + NW'(1);
   assign rise_tick_o = mclk_tick && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase   <= '0;
         started <= 1'b0;
         pdm_q   <= 1'b0;
         armed   <= 1'b0;
         dcnt    <= '0;
         stb_q   <= 1'b0;
         dat_q   <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (mclk_tick) begin
            phase   <= nxt_phase;
            started <= 1'b1;
            pdm_q   <= ({1'b0, nxt_phase} < half);
         end
         if (rise_tick_o) begin
            if (d_i == '0) begin
               stb_q <= 1'b1;
               dat_q <= din;
               armed <= 1'b0;
            end else begin
               armed <= 1'b1;
               dcnt  <= d_i;
            end
         end else if (core_tick && armed) begin
            dcnt <= dcnt - DW'(1);
            if (dcnt == DW'(1)) begin
               armed <= 1'b0;
               stb_q <= 1'b1;
               dat_q <= din;
            end
         end
      end
   end

   assign pdm_clk_o = pdm_q;
   assign smp_stb_o = stb_q;
   assign smp_dat_o = dat_q;

   // R5: a sampler strobe never lasts two cycles
   a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);
   // R3 / R4: the pin clock moves only on a master enable, or when stopping
   a_r4_edge_on_master: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pdm_q) |-> ($past(mclk_tick) || !$past(run)));
   // R6: the captured bit changes only together with a strobe, or when stopping
   a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dat_q) |-> (stb_q || !$past(run)));
endmodule

// File: rtl/pdm_dec_strobe.sv
module pdm_dec_strobe #(
   parameter int RW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          rise_tick,
   input  logic [RW-1:0] rate_i,
   output logic          pcm_stb_o
);
   logic [RW:0] cnt, lim;
   logic        pcm_q;

   assign lim = {rate_i, 1'b0} - (RW+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt   <= '0;
         pcm_q <= 1'b0;
      end else begin
         pcm_q <= 1'b0;
         if (rise_tick && (rate_i != '0)) begin
            if (cnt == lim) begin
               cnt   <= '0;
               pcm_q <= 1'b1;
            end else begin
               cnt <= cnt + (RW+1)'(1);
            end
         end
      end
   end

   assign pcm_stb_o = pcm_q;

   // R7: a zero rate never yields a PCM strobe
   a_r7_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rate_i == '0) |=> !pcm_q);
   // R7: the decimation count stays inside its window
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rate_i != '0) |-> (cnt <= lim));
endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
   import pdm_clkgen_pkg::*;
#(
   parameter int SEL_W  = DEF_SEL_W,
   parameter int DIV_W  = DEF_DIV_W,
   parameter int DLY_W  = DEF_DLY_W,
   parameter int RATE_W = DEF_RATE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SEL_W-1:0]  core_div_sel,
   input  logic [SEL_W-1:0]  mclk_div_sel,
   input  logic [DIV_W-1:0]  out_div,
   input  logic [DLY_W-1:0]  smp_delay,
   input  logic [RATE_W-1:0] dec_rate,
   input  logic              pdm_din,
   output logic              pdm_clk_o,
   output logic              smp_stb_o,
   output logic              smp_dat_o,
   output logic              pcm_stb_o
);
   localparam int STAGES = PRESCALE_STAGES;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must be 1..4");
   end
   if (DIV_W < 1 || DLY_W < 1 || RATE_W < 1) begin : g_bad_width
      $error("divider, delay and rate widths must be at least 1");
   end
   if (STAGES != 2) begin : g_bad_stages
      $error("the shaper expects a core and a master enable");
   end

   // settings captured while stopped, frozen while running
   logic [STAGES-1:0][SEL_W-1:0] sel_q;
   logic [DIV_W-1:0]             n_q;
   logic [DLY_W-1:0]             d_q;
   logic [RATE_W-1:0]            rate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         n_q    <= '0;
         d_q    <= '0;
         rate_q <= '0;
      end else if (!en) begin
         sel_q  <= {mclk_div_sel, core_div_sel};
         n_q    <= out_div;
         d_q    <= smp_delay;
         rate_q <= dec_rate;
      end
   end

   logic [STAGES:0] tick;
   assign tick[0] = 1'b1;

   for (genvar g = 0; g < STAGES; g++) begin : g_pre
      pdm_ce_div #(.W(SEL_W)) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (en),
         .tick_i (tick[g]),
         .lim_i  (sel_q[g]),
         .tick_o (tick[g+1])
      );
   end

   logic rise_tick;

   pdm_clk_shaper #(.NW(DIV_W), .DW(DLY_W)) u_shape (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (en),
      .core_tick   (tick[1]),
      .mclk_tick   (tick[STAGES]),
      .n_i         (n_q),
      .d_i         (d_q),
      .din         (pdm_din),
      .pdm_clk_o   (pdm_clk_o),
      .rise_tick_o (rise_tick),
      .smp_stb_o   (smp_stb_o),
      .smp_dat_o   (smp_dat_o)
   );

   pdm_dec_strobe #(.RW(RATE_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (en),
      .rise_tick (rise_tick),
      .rate_i    (rate_q),
      .pcm_stb_o (pcm_stb_o)
   );

   // R8: settings do not move while running
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> ($stable(sel_q) && $stable(n_q) && $stable(d_q) && $stable(rate_q)));
   // R8: stopping clears every output on the next cycle
   a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pdm_clk_o && !smp_stb_o && !pcm_stb_o && !smp_dat_o));
   // R7: a PCM strobe lands on a rising pin-clock edge
   a_r7_pcm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_stb_o |-> (pdm_clk_o && !$past(pdm_clk_o)));
endmodule

// File: tb/sim_pdm_clkgen.sv
`timescale 1ns/1ps
module sim_pdm_clkgen;
   logic       clk = 1'b0;
   logic       rst_n, en, pdm_din;
   logic [1:0] core_sel, mclk_sel;
   logic [3:0] out_div;
   logic [2:0] dly;
   logic [6:0] rate;
   logic       pdm_clk, stb, dat, pcm;

   int nchk = 0;
   int nerr = 0;
   int cyc_all = 0;
   bit [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   pdm_clkgen u0 (
      .clk(clk), .rst_n(rst_n), .en(en),
      .core_div_sel(core_sel), .mclk_div_sel(mclk_sel),
      .out_div(out_div), .smp_delay(dly), .dec_rate(rate),
      .pdm_din(pdm_din),
      .pdm_clk_o(pdm_clk), .smp_stb_o(stb), .smp_dat_o(dat), .pcm_stb_o(pcm)
   );

   // core, master, N, delay, rate, period, high, offset (-1: none), pcm interval
   localparam int NV = 8;
   localparam int VEC [NV][9] = '{
      '{1, 1,  3, 0, 2,   4,  2,  0,   16},
      '{2, 1,  1, 1, 1,   4,  2,  2,    8},
      '{1, 3,  4, 7, 3,  15,  9,  7,   90},
      '{4, 2,  2, 5, 1,  24, 16, 20,   48},
      '{3, 4, 15, 3, 4, 192, 96,  9, 1536},
      '{1, 1, 15, 7, 0,  16,  8,  7,    0},
      '{2, 2,  6, 2, 2,  28, 16,  4,  112},
      '{1, 1,  1, 2, 1,   2,  1, -1,    4}
   };

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc_all++;
      if (cyc_all > 150000) begin
         chk(1'b0, "watchdog", "cycle limit", cyc_all, 150000);
         finish_run();
      end
   end

   task automatic run_vec(input int c, input int m, input int n, input int d,
                          input int r, input int per, input int hi,
                          input int off, input int pcm_p, input bit perturb);
      int len, last_rise, nrise, per_bad, last_per, hi_run, hi_bad, last_hi, nfall;
      int nstb, off_bad, last_off, dat_bad, npcm, last_pcm, pcm_bad, pcm_norise;
      bit p, prev, rise, fall;
      en       = 1'b0;
      core_sel = 2'(c - 1);
      mclk_sel = 2'(m - 1);
      out_div  = 4'(n);
      dly      = 3'(d);
      rate     = 7'(r);
      repeat (4) @(negedge clk);
      en = 1'b1;
      len = (r > 0) ? (2 * pcm_p + 3 * per + 10) : (6 * per + 10);
      last_rise = -1; nrise = 0; per_bad = 0; last_per = per;
      hi_run = 0; hi_bad = 0; last_hi = hi; nfall = 0;
      nstb = 0; off_bad = 0; last_off = off; dat_bad = 0;
      npcm = 0; last_pcm = -1; pcm_bad = 0; pcm_norise = 0;
      prev = 1'b0;
      for (int k = 1; k <= len; k++) begin
         @(negedge clk);
         p    = pdm_clk;
         rise = p && !prev;
         fall = !p && prev;
         if (rise) begin
            if (last_rise >= 0 && (k - last_rise) != per) begin
               per_bad++; last_per = k - last_rise;
            end
            last_rise = k;
            nrise++;
         end
         if (p) hi_run++;
         if (fall) begin
            nfall++;
            if (hi_run != hi) begin hi_bad++; last_hi = hi_run; end
            hi_run = 0;
         end
         if (stb) begin
            nstb++;
            if (off < 0 || (k - last_rise) != off) begin
               off_bad++; last_off = k - last_rise;
            end
            if (dat !== pdm_din) dat_bad++;
         end
         if (pcm) begin
            npcm++;
            if (!rise) pcm_norise++;
            if (npcm == 1 && nrise != 2 * r) pcm_bad++;
            if (last_pcm >= 0 && (k - last_pcm) != pcm_p) pcm_bad++;
            last_pcm = k;
         end
         prev = p;
         if (perturb && k == 5) begin
            core_sel = 2'd3; mclk_sel = 2'd3; out_div = 4'd15; dly = 3'd6; rate = 7'd0;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pdm_din = lfsr[0];
      end
      en = 1'b0;
      // R1 R2 R3: pin-clock period from the cascaded dividers
      chk(per_bad == 0 && nrise >= 3, "R1 R2 R3", "pin clock period", last_per, per);
      // R4: high time
      chk(hi_bad == 0 && nfall >= 2, "R4", "pin clock high time", last_hi, hi);
      // R5: strobe offset and count
      if (off >= 0)
         chk(off_bad == 0 && nstb >= nrise - 1 && nstb <= nrise, "R5",
             "strobe offset", last_off, off);
      else
         chk(nstb == 0, "R5", "strobe count with offset beyond period", nstb, 0);
      // R6: captured data matches the driven bit
      chk(dat_bad == 0, "R6", "captured data mismatches", dat_bad, 0);
      // R7: PCM strobe cadence
      if (r > 0)
         chk(pcm_bad == 0 && pcm_norise == 0 && npcm >= 2, "R7",
             "pcm strobe count", npcm, 2);
      else
         chk(npcm == 0, "R7", "pcm strobes at zero rate", npcm, 0);
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b0; pdm_din = 1'b0;
      core_sel = '0; mclk_sel = '0; out_div = 4'd3; dly = '0; rate = 7'd2;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk({pdm_clk, stb, dat, pcm} == 4'b0, "R8", "outputs in reset",
          int'({pdm_clk, stb, dat, pcm}), 0);
      rst_n = 1'b1;
      // R8: held disabled, nothing toggles
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            pdm_din = k[0];
            if (pdm_clk || stb || pcm || dat) seen++;
         end
         chk(seen == 0, "R8", "activity while disabled", seen, 0);
      end
      // table of settings and expected timings
      foreach (VEC[i]) begin
         run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                 VEC[i][5], VEC[i][6], VEC[i][7], VEC[i][8], 1'b0);
      end
      // R8: settings changed while running are ignored until re-enable
      run_vec(1, 1, 3, 0, 2, 4, 2, 0, 16, 1'b1);
      repeat (2) @(negedge clk);
      chk({pdm_clk, stb, pcm} == 3'b0, "R8", "outputs after disable",
          int'({pdm_clk, stb, pcm}), 0);
      // R8: after re-enable the previously ignored style of setting now applies
      run_vec(2, 2, 6, 2, 2, 28, 16, 4, 112, 1'b0);
      finish_run();
   end
endmodule